// File: doc/BRIEF.md
# Converter Output Formatter with Test Patterns

This block is the last digital stage of a 7-bit pipelined converter. Raw 7-bit codes arrive from the comparator logic with a valid flag. They pass through a capture register and an output latch, so a code reaches the output bus two clock edges after it is sampled. Two static select inputs choose the number format applied on the way into the output latch. One select inverts the most significant bit. The other inverts the six lower bits as a group. Together they give straight binary, inverted binary, two's complement and inverted two's complement.

A test input lets downstream interface logic be checked against known words. While it is high, the output latch loads alternating complementary patterns instead of converted data, starting with 1010101. The capture stage keeps running underneath. When the test input drops, live data resumes on the very next edge. A one-cycle data-ready strobe marks each new output word.

Top module: `adc_out_fmt`

## Requirements
- R1: With test low, output bit 6 equals the MSB of the code sampled two edges earlier, XOR `msb_flip`.
- R2: With test low, output bits 5..0 equal the lower six bits of the code sampled two edges earlier, each XOR `low_flip`.
- R3: The select pair {`msb_flip`,`low_flip`} encodes the format: 00 is straight binary, 11 is inverted binary (all bits flipped), 10 is two's complement (code 1000000 gives 0000000), 01 is inverted two's complement (code 1000000 gives 1111111).
- R4: A code sampled with `code_vld` high at edge N appears on `dout` after edge N+1, provided `test_en` is low at edge N+1.
- R5: At the first edge at which `test_en` is sampled high after being low (or after reset), `dout` becomes 1010101 (bit 6 down to bit 0).
- R6: On each further edge with `test_en` sampled high, `dout` becomes the bitwise complement of its previous value, alternating between 1010101 and 0101010.
- R7: The capture stage keeps advancing in test mode. At the first edge with `test_en` low, `dout` shows the formatted code sampled one edge earlier, while test mode was still active.
- R8: Test words are not affected by `msb_flip` or `low_flip`.
- R9: `drdy` is high for the cycle after each edge that loads a new word. That is every edge with `test_en` high, and every edge with `test_en` low whose captured code was valid.
- R10: With `test_en` low and no valid captured code, `dout` holds its value and `drdy` is low.
- R11: Synchronous reset (`rst` high at an edge) clears `dout` to 0, clears `drdy`, empties the capture stage and restarts the pattern sequence, so the next test entry begins with 1010101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 7 | Raw conversion code from the comparator logic |
| code_vld | input | 1 | Marks `code_in` as a valid sample |
| msb_flip | input | 1 | Inverts output bit 6 when high |
| low_flip | input | 1 | Inverts output bits 5..0 when high |
| test_en | input | 1 | Replaces output data with alternating test words |
| dout | output | 7 | Formatted output word, bit 6 is the MSB |
| drdy | output | 1 | One-cycle strobe for each new output word |

## Verification
On every cycle the assertions check four things: the two-edge path from a valid sample to the formatted output, the start of every test burst at 1010101, the complement alternation inside a burst with the word always one of the two patterns, and the strobe and reset behaviour. The bench scenarios show the rest. They step through the four named formats on chosen codes, hold the output across gaps in valid data, and change the select inputs in the middle of a burst. They also check the hand-over from test words back to a code captured during the burst, and that the pattern phase restarts after a reset taken mid-burst.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  localparam int unsigned CODE_W = 7;

  // {msb_flip, low_flip}
  typedef enum logic [1:0] {
    FMT_BINARY     = 2'b00,
    FMT_INV_TWOS   = 2'b01,
    FMT_TWOS       = 2'b10,
    FMT_INV_BINARY = 2'b11
  } fmt_sel_t;

  // Applies the two inversion controls to a raw code.
  function automatic logic [CODE_W-1:0] format_code(
      input logic [CODE_W-1:0] raw,
      input logic              msb_flip,
      input logic              low_flip);
    logic [CODE_W-1:0] mask;
    mask = {msb_flip, {(CODE_W-1){low_flip}}};
    return raw ^ mask;
  endfunction

  // Phase 0 word: ones on even bit positions (1010101 for seven bits).
  function automatic logic [CODE_W-1:0] test_word(input logic phase);
    logic [CODE_W-1:0] w;
    for (int i = 0; i < CODE_W; i++) begin
      w[i] = ((i % 2) == 0);
    end
    return phase ? ~w : w;
  endfunction

endpackage

// File: rtl/adc_fmt_capture.sv
module adc_fmt_capture #(
  parameter int unsigned W = adc_fmt_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code_in,
  input  logic         code_vld,
  output logic [W-1:0] stage_code,
  output logic         stage_vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_code <= '0;
      stage_vld  <= 1'b0;
    end else begin
      stage_code <= code_in;
      stage_vld  <= code_vld;
    end
  end

endmodule

// File: rtl/adc_fmt_test_seq.sv
module adc_fmt_test_seq #(
  parameter int unsigned W = adc_fmt_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_en,
  output logic [W-1:0] pat_word,
  output logic         test_entry
);
  import adc_fmt_pkg::*;

  logic phase_q;
  logic test_prev_q;

  assign pat_word   = test_word(phase_q);
  assign test_entry = test_en && !test_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= 1'b0;
      test_prev_q <= 1'b0;
    end else begin
      test_prev_q <= test_en;
      phase_q     <= test_en ? ~phase_q : 1'b0;
    end
  end

  // Every burst begins on the phase-0 word.
  p_entry_phase_r5: assert property (@(posedge clk) disable iff (rst)
    test_entry |-> (phase_q == 1'b0));

endmodule

// File: rtl/adc_fmt_out_latch.sv
module adc_fmt_out_latch #(
  parameter int unsigned W = adc_fmt_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_en,
  input  logic [W-1:0] stage_code,
  input  logic         stage_vld,
  input  logic         msb_flip,
  input  logic         low_flip,
  input  logic [W-1:0] pat_word,
  output logic [W-1:0] dout,
  output logic         drdy,
  output logic         pat_q
);
  import adc_fmt_pkg::*;

  logic [W-1:0] fmt_word;
  logic         load;

  assign fmt_word = format_code(stage_code, msb_flip, low_flip);
  assign load     = test_en || stage_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      drdy  <= 1'b0;
      pat_q <= 1'b0;
    end else begin
      drdy  <= load;
      pat_q <= test_en;
      if (test_en) begin
        dout <= pat_word;
      end else if (stage_vld) begin
        dout <= fmt_word;
      end
    end
  end

  // Consecutive test words are complements.
  p_alternate_r6: assert property (@(posedge clk) disable iff (rst)
    (pat_q && test_en) |=> (dout == ~$past(dout)));

  // A test word is one of the two fixed patterns whatever the selects.
  p_test_word_r8: assert property (@(posedge clk) disable iff (rst)
    pat_q |-> (dout == test_word(1'b0) || dout == test_word(1'b1)));

  // Test mode produces a strobe every cycle.
  p_drdy_test_r9: assert property (@(posedge clk) disable iff (rst)
    test_en |=> drdy);

  // No new word means hold and no strobe.
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !stage_vld) |=> (!drdy && $stable(dout)));

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int unsigned CODE_W = adc_fmt_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_vld,
  input  logic              msb_flip,
  input  logic              low_flip,
  input  logic              test_en,
  output logic [CODE_W-1:0] dout,
  output logic              drdy
);
  import adc_fmt_pkg::*;

  logic [CODE_W-1:0] stage_code;
  logic              stage_vld;
  logic [CODE_W-1:0] pat_word;
  logic              test_entry;
  logic              pat_q;

  adc_fmt_capture #(.W(CODE_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .code_in    (code_in),
    .code_vld   (code_vld),
    .stage_code (stage_code),
    .stage_vld  (stage_vld)
  );

  adc_fmt_test_seq #(.W(CODE_W)) u_test_seq (
    .clk        (clk),
    .rst        (rst),
    .test_en    (test_en),
    .pat_word   (pat_word),
    .test_entry (test_entry)
  );

  adc_fmt_out_latch #(.W(CODE_W)) u_out_latch (
    .clk        (clk),
    .rst        (rst),
    .test_en    (test_en),
    .stage_code (stage_code),
    .stage_vld  (stage_vld),
    .msb_flip   (msb_flip),
    .low_flip   (low_flip),
    .pat_word   (pat_word),
    .dout       (dout),
    .drdy       (drdy),
    .pat_q      (pat_q)
  );

  // Edges since reset, saturating at 2, so $past depth 2 is meaningful.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // End-to-end two-edge path with formatting (R1, R2, R4, R7).
  p_pipe_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2 && !test_en && $past(code_vld)) |=>
      (dout == format_code($past(code_in, 2), $past(msb_flip), $past(low_flip))));

  // First word of any burst is the phase-0 pattern.
  p_first_pattern_r5: assert property (@(posedge clk) disable iff (rst)
    test_entry |=> (dout == test_word(1'b0)));

  // Reset clears the output side.
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (dout == '0 && !drdy && !pat_q));

endmodule

// File: tb/test_adc_out_fmt.sv
module test_adc_out_fmt;

  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] PAT_A = 7'b1010101;
  localparam logic [6:0] PAT_B = 7'b0101010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] code_in = '0;
  logic       code_vld = 1'b0;
  logic       msb_flip = 1'b0;
  logic       low_flip = 1'b0;
  logic       test_en = 1'b0;
  logic [6:0] dout;
  logic       drdy;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_fmt i_adc_out_fmt (
    .clk(clk), .rst(rst), .code_in(code_in), .code_vld(code_vld),
    .msb_flip(msb_flip), .low_flip(low_flip), .test_en(test_en),
    .dout(dout), .drdy(drdy)
  );

  // Expected format, by named format rather than by bit mask.
  function automatic logic [6:0] expect_fmt(input logic [6:0] c, input logic m, input logic l);
    case ({m, l})
      2'b00:   return c;
      2'b11:   return ~c;
      2'b10:   return c ^ 7'h40;
      default: return c ^ 7'h3F;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive inputs, pass one rising edge, return at the falling edge.
  task automatic step(input logic [6:0] c, input logic v, input logic t);
    code_in = c; code_vld = v; test_en = t;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(7'h00, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R11 dout", dout, 7'h00);
    check("R11 drdy", {6'd0, drdy}, 7'd0);
  endtask

  task automatic t_formats();
    logic [6:0] codes [5] = '{7'h40, 7'h00, 7'h7F, 7'h3F, 7'h25};
    for (int f = 0; f < 4; f++) begin
      msb_flip = f[1]; low_flip = f[0];
      step(codes[0], 1'b1, 1'b0);
      for (int i = 1; i < 5; i++) begin
        step(codes[i], 1'b1, 1'b0);
        check("R1 R2 R3 R4 format", dout, expect_fmt(codes[i-1], f[1], f[0]));
        check("R9 drdy normal", {6'd0, drdy}, 7'd1);
      end
    end
    // Named corner: mid-scale code in two's complement modes.
    msb_flip = 1; low_flip = 0;
    step(7'h40, 1'b1, 1'b0); step(7'h00, 1'b0, 1'b0);
    check("R3 twos of 1000000", dout, 7'h00);
    msb_flip = 0; low_flip = 1;
    step(7'h40, 1'b1, 1'b0); step(7'h00, 1'b0, 1'b0);
    check("R3 inv twos of 1000000", dout, 7'h7F);
  endtask

  task automatic t_hold();
    msb_flip = 0; low_flip = 0;
    step(7'h11, 1'b1, 1'b0);
    step(7'h22, 1'b0, 1'b0);
    check("R4 before gap", dout, 7'h11);
    step(7'h33, 1'b0, 1'b0);
    check("R10 hold dout", dout, 7'h11);
    check("R10 drdy low", {6'd0, drdy}, 7'd0);
    step(7'h44, 1'b0, 1'b0);
    check("R10 hold again", dout, 7'h11);
  endtask

  task automatic t_test_burst();
    msb_flip = 1; low_flip = 0;
    step(7'h05, 1'b1, 1'b0);
    step(7'h06, 1'b1, 1'b1);
    check("R5 entry word", dout, PAT_A);
    check("R9 drdy test", {6'd0, drdy}, 7'd1);
    msb_flip = 0; low_flip = 1;
    step(7'h07, 1'b1, 1'b1);
    check("R6 second word", dout, PAT_B);
    check("R8 selects ignored", dout, PAT_B);
    msb_flip = 1; low_flip = 1;
    step(7'h08, 1'b0, 1'b1);
    check("R6 third word", dout, PAT_A);
    check("R9 drdy without valid", {6'd0, drdy}, 7'd1);
    step(7'h09, 1'b1, 1'b1);
    check("R6 fourth word", dout, PAT_B);
    step(7'h0A, 1'b1, 1'b0);
    check("R7 resume with code from burst", dout, expect_fmt(7'h09, 1'b1, 1'b1));
    step(7'h0B, 1'b1, 1'b0);
    check("R4 next after resume", dout, expect_fmt(7'h0A, 1'b1, 1'b1));
    // Re-entry after a burst that ended on the phase-1 word.
    step(7'h0C, 1'b1, 1'b1);
    check("R5 re-entry word", dout, PAT_A);
    step(7'h0D, 1'b1, 1'b1);
    check("R6 re-entry second", dout, PAT_B);
  endtask

  task automatic t_reset_mid_burst();
    step(7'h01, 1'b1, 1'b1);
    rst = 1'b1;
    step(7'h02, 1'b1, 1'b1);
    rst = 1'b0;
    check("R11 dout cleared", dout, 7'h00);
    check("R11 drdy cleared", {6'd0, drdy}, 7'd0);
    step(7'h03, 1'b1, 1'b1);
    check("R11 phase restarted", dout, PAT_A);
    step(7'h04, 1'b1, 1'b0);
    check("R11 capture cleared then filled", dout, expect_fmt(7'h03, msb_flip, low_flip));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_formats();
    t_hold();
    t_test_burst();
    t_reset_mid_burst();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule